// File: doc/BRIEF.md
# Locked Configuration-Port Watchdog

This block is a watchdog timer that lives behind a pair of byte-wide configuration ports: an index port that chooses a register and a data port that reads or writes it. The configuration space starts locked. Software opens it by writing a two-byte key to the index port, then chooses the watchdog page through a page register. Once the page is selected, software sets the enable bit, the count unit, the 8-bit timeout and the reload sources. It closes the space again with a separate closing key. While the space is locked, the data port does nothing and every read returns all ones.

Once enabled with a nonzero count, the counter steps down once per unit. The unit is one pulse of the seconds tick input, or `SECS_PER_MIN` such pulses in minute mode. When the count reaches zero, the timeout output goes high and stays high until software writes a new count. Keyboard and mouse event pulses can each be allowed to restore the last written timeout value, so ordinary user activity keeps the watchdog from expiring.

The host bus is a plain strobe bus rather than a stream. Every access completes in one cycle and there is no back-pressure. A read strobe to either port is answered by `io_rvalid` with data on the following cycle, and the answer cannot be stalled.

Top module: `cfgport_watchdog`

## Requirements
- R1: After reset the space is locked, the page register is 0x00, all watchdog registers and the count are 0, and `wdt_timeout` and `io_rvalid` are low.
- R2: While the space is locked, data-port writes change no register, and reads of either port return 0xFF.
- R3: The space opens only after two index-port writes of 0x87 with no other port write between them. Any other index value or any data-port write restarts the key. When the space is open, an index-port read returns the current index.
- R4: An index-port write of 0xAA while the space is open locks it again. The index and page registers keep their values.
- R5: Index 0x07 is the page register and can always be reached while the space is open. Indices 0x30, 0xF5, 0xF6 and 0xF7 can be reached only while the page register holds 0x08. Other accesses read 0x00 and discard writes.
- R6: 0x30 bit 0 is the enable bit. 0xF5 bit 3 selects the unit (0 = seconds, 1 = minutes). 0xF7 bit 6 allows keyboard reload and bit 7 allows mouse reload. All other bits of these registers read 0.
- R7: In seconds mode, an enabled nonzero count drops by one on each `sec_tick` pulse. A disabled count holds its value.
- R8: In minute mode, the count drops once every `SECS_PER_MIN` tick pulses, and the tick phase restarts whenever the count is loaded.
- R9: When the count steps from 1 to 0, `wdt_timeout` goes high. The count then stays at 0 and `wdt_timeout` stays high until 0xF6 is written, and that write clears `wdt_timeout`.
- R10: A keyboard or mouse event pulse whose reload bit is set restores the last value written to 0xF6, clears `wdt_timeout` and restarts the tick phase. When its bit is clear, the pulse has no effect.
- R11: `io_rvalid` goes high exactly one cycle after a read strobe to either port. A read of 0xF6 returns the live count.
- R12: When a host write to 0xF6, a reload event and a tick pulse arrive in the same cycle, the host write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 8 | Port address (index at `IDX_PORT`, data at `IDX_PORT`+1) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with `io_rvalid` |
| io_rvalid | output | 1 | Read response, one cycle after `io_rd` |
| sec_tick | input | 1 | One-cycle pulse per second |
| kbd_evt | input | 1 | Keyboard activity pulse |
| mouse_evt | input | 1 | Mouse activity pulse |
| wdt_timeout | output | 1 | High once the count has expired |

## Verification
The bench builds the block with `SECS_PER_MIN` set to 4 instead of 60. A full minute-mode period, the phase restart on load, and an expiry in minute mode therefore all fit into a few dozen tick pulses. The default `IDX_PORT` of 0x2E is kept, so the unlock key, the page select and the closing key are exercised on the real port pair. Ticks, reload events and a host write are also driven into the same cycle to reach the priority corner.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;

  // Key values written to the index port
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  // Index values
  localparam logic [7:0] IX_PAGE  = 8'h07;
  localparam logic [7:0] IX_ENAB  = 8'h30;
  localparam logic [7:0] IX_UNIT  = 8'hF5;
  localparam logic [7:0] IX_COUNT = 8'hF6;
  localparam logic [7:0] IX_SRC   = 8'hF7;

  localparam logic [7:0] PAGE_WDOG = 8'h08;

  // Implemented bits of each control register
  localparam logic [7:0] ENAB_MASK = 8'h01;
  localparam logic [7:0] UNIT_MASK = 8'h08;
  localparam logic [7:0] SRC_MASK  = 8'hC0;

  localparam int ENAB_BIT  = 0;
  localparam int UNIT_BIT  = 3;
  localparam int KBD_BIT   = 6;
  localparam int MOUSE_BIT = 7;

endpackage

// File: rtl/cfgwd_gate.sv
module cfgwd_gate
  import cfgwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic [7:0] index_o,
  output logic [7:0] page_o
);

  gate_state_e state_q;
  logic [7:0]  index_q;
  logic [7:0]  page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GATE_LOCKED;
      index_q <= 8'h00;
      page_q  <= 8'h00;
    end else begin
      unique case (state_q)
        GATE_LOCKED: begin
          if (idx_wr && wdata == KEY_OPEN) state_q <= GATE_HALF;
        end
        GATE_HALF: begin
          if (idx_wr && wdata == KEY_OPEN) state_q <= GATE_OPEN;
          else if (idx_wr || dat_wr)       state_q <= GATE_LOCKED;
        end
        GATE_OPEN: begin
          if (idx_wr) begin
            if (wdata == KEY_CLOSE) state_q <= GATE_LOCKED;
            else                    index_q <= wdata;
          end
          if (dat_wr && index_q == IX_PAGE) page_q <= wdata;
        end
        default: state_q <= GATE_LOCKED;
      endcase
    end
  end

  assign open_o  = (state_q == GATE_OPEN);
  assign index_o = index_q;
  assign page_o  = page_q;

  // R3
  open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(idx_wr && wdata == KEY_OPEN));

  // R4
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && idx_wr && wdata == KEY_CLOSE) |=> !open_o);

  // R2
  locked_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_o) |=> $stable(page_o));

endmodule

// File: rtl/cfgwd_regs.sv
module cfgwd_regs
  import cfgwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wd,
  input  logic       dat_wr,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic       enab,
  output logic       unit_min,
  output logic       kbd_src,
  output logic       mouse_src,
  output logic       cnt_ld,
  output logic [7:0] ctl_rdata
);

  logic [7:0] enab_q, unit_q, src_q;
  logic       wr_ok;

  assign wr_ok = sel_wd && dat_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enab_q <= 8'h00;
      unit_q <= 8'h00;
      src_q  <= 8'h00;
    end else if (wr_ok) begin
      if (index == IX_ENAB) enab_q <= wdata & ENAB_MASK;
      if (index == IX_UNIT) unit_q <= wdata & UNIT_MASK;
      if (index == IX_SRC)  src_q  <= wdata & SRC_MASK;
    end
  end

  always_comb begin
    unique case (index)
      IX_ENAB: ctl_rdata = enab_q;
      IX_UNIT: ctl_rdata = unit_q;
      IX_SRC:  ctl_rdata = src_q;
      default: ctl_rdata = 8'h00;
    endcase
  end

  assign enab      = enab_q[ENAB_BIT];
  assign unit_min  = unit_q[UNIT_BIT];
  assign kbd_src   = src_q[KBD_BIT];
  assign mouse_src = src_q[MOUSE_BIT];
  assign cnt_ld    = wr_ok && index == IX_COUNT;

  // R2
  locked_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_wd) |=> ($stable(enab) && $stable(unit_min) && $stable(kbd_src) && $stable(mouse_src)));

  // R6
  ctl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(enab_q & ~ENAB_MASK) == 0 && $countones(src_q & ~SRC_MASK) == 0);

endmodule

// File: rtl/cfgwd_counter.sv
module cfgwd_counter #(
  parameter int SECS_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enab,
  input  logic       unit_min,
  input  logic       kbd_src,
  input  logic       mouse_src,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  input  logic       sec_tick,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] count_o,
  output logic       timeout_o
);

  localparam int PW = (SECS_PER_MIN > 2) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [PW-1:0] PHASE_LAST = PW'(SECS_PER_MIN - 1);

  logic [7:0]    count_q, reload_q;
  logic [PW-1:0] phase_q;
  logic          timeout_q;
  logic          reload;
  logic          run;

  assign reload = (kbd_src && kbd_evt) || (mouse_src && mouse_evt);
  assign run    = enab && count_q != 8'h00 && sec_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= 8'h00;
      reload_q  <= 8'h00;
      phase_q   <= '0;
      timeout_q <= 1'b0;
    end else if (ld) begin
      count_q   <= ld_val;
      reload_q  <= ld_val;
      phase_q   <= '0;
      timeout_q <= 1'b0;
    end else if (reload) begin
      count_q   <= reload_q;
      phase_q   <= '0;
      timeout_q <= 1'b0;
    end else if (run) begin
      if (unit_min && phase_q != PHASE_LAST) begin
        phase_q <= phase_q + 1'b1;
      end else begin
        phase_q <= '0;
        count_q <= count_q - 8'd1;
        if (count_q == 8'd1) timeout_q <= 1'b1;
      end
    end
  end

  assign count_o   = count_q;
  assign timeout_o = timeout_q;

  // R9
  timeout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> count_o == 8'h00);

  // R9
  timeout_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(count_o) == 8'd1);

  // R7
  no_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o > $past(count_o)) |-> $past(ld || reload));

  // R12
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (count_o == $past(ld_val) && !timeout_o));

endmodule

// File: rtl/cfgport_watchdog.sv
module cfgport_watchdog
  import cfgwd_pkg::*;
#(
  parameter logic [7:0] IDX_PORT     = 8'h2E,
  parameter int         SECS_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       io_rvalid,
  input  logic       sec_tick,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       wdt_timeout
);

  localparam logic [7:0] DAT_PORT = IDX_PORT + 8'd1;

  logic       idx_wr, dat_wr, idx_rd, dat_rd;
  logic       gate_open;
  logic [7:0] index, page;
  logic       sel_wd;
  logic       enab, unit_min, kbd_src, mouse_src, cnt_ld;
  logic [7:0] ctl_rdata, count;
  logic [7:0] rdata_d, rdata_q;
  logic       rvalid_q;

  assign idx_wr = io_wr && io_addr == IDX_PORT;
  assign dat_wr = io_wr && io_addr == DAT_PORT;
  assign idx_rd = io_rd && io_addr == IDX_PORT;
  assign dat_rd = io_rd && io_addr == DAT_PORT;
  assign sel_wd = gate_open && page == PAGE_WDOG;

  cfgwd_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .dat_wr  (dat_wr),
    .wdata   (io_wdata),
    .open_o  (gate_open),
    .index_o (index),
    .page_o  (page)
  );

  cfgwd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wd    (sel_wd),
    .dat_wr    (dat_wr),
    .index     (index),
    .wdata     (io_wdata),
    .enab      (enab),
    .unit_min  (unit_min),
    .kbd_src   (kbd_src),
    .mouse_src (mouse_src),
    .cnt_ld    (cnt_ld),
    .ctl_rdata (ctl_rdata)
  );

  cfgwd_counter #(.SECS_PER_MIN(SECS_PER_MIN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enab      (enab),
    .unit_min  (unit_min),
    .kbd_src   (kbd_src),
    .mouse_src (mouse_src),
    .kbd_evt   (kbd_evt),
    .mouse_evt (mouse_evt),
    .sec_tick  (sec_tick),
    .ld        (cnt_ld),
    .ld_val    (io_wdata),
    .count_o   (count),
    .timeout_o (wdt_timeout)
  );

  always_comb begin
    if (!gate_open) begin
      rdata_d = 8'hFF;
    end else if (idx_rd) begin
      rdata_d = index;
    end else if (index == IX_PAGE) begin
      rdata_d = page;
    end else if (!sel_wd) begin
      rdata_d = 8'h00;
    end else if (index == IX_COUNT) begin
      rdata_d = count;
    end else begin
      rdata_d = ctl_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= idx_rd || dat_rd;
      if (idx_rd || dat_rd) rdata_q <= rdata_d;
    end
  end

  assign io_rdata  = rdata_q;
  assign io_rvalid = rvalid_q;

  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> ($past(gate_open) || io_rdata == 8'hFF));

  // R11
  rvalid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (io_addr == IDX_PORT || io_addr == DAT_PORT)) |=> io_rvalid);

endmodule

// File: tb/tb_cfgport_watchdog.sv
module tb_cfgport_watchdog;

  localparam logic [7:0] IX = 8'h2E;
  localparam logic [7:0] DT = 8'h2F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       io_rvalid;
  logic       sec_tick = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
  logic       wdt_timeout;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cfgport_watchdog #(.IDX_PORT(8'h2E), .SECS_PER_MIN(4)) dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .sec_tick(sec_tick), .kbd_evt(kbd_evt), .mouse_evt(mouse_evt),
    .wdt_timeout(wdt_timeout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && io_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", io_rdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(io_rdata == e, t, io_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] i, input logic [7:0] v);
    wr(IX, i);
    wr(DT, v);
  endtask

  task automatic getreg(input logic [7:0] i, input logic [7:0] e, input string t);
    wr(IX, i);
    rd(DT, e, t);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic kbd();
    @(negedge clk); kbd_evt = 1'b1;
    @(negedge clk); kbd_evt = 1'b0;
  endtask

  task automatic mouse();
    @(negedge clk); mouse_evt = 1'b1;
    @(negedge clk); mouse_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wdt_timeout == 1'b0, "R1 timeout after reset", wdt_timeout, 0);
    chk(io_rvalid == 1'b0, "R1 rvalid after reset", io_rvalid, 0);

    // locked reads and a locked write attempt
    rd(DT, 8'hFF, "R2 locked data read");
    rd(IX, 8'hFF, "R2 locked index read");
    wr(IX, 8'h30);
    wr(DT, 8'h01);

    // broken key sequences
    wr(IX, 8'h87); wr(IX, 8'h30); wr(IX, 8'h87);
    rd(DT, 8'hFF, "R3 key broken by other index");
    wr(IX, 8'h11);
    wr(IX, 8'h87); wr(DT, 8'h00); wr(IX, 8'h87);
    rd(DT, 8'hFF, "R3 key broken by data write");
    wr(IX, 8'h11);
    wr(IX, 8'h87); wr(IX, 8'h87);
    rd(IX, 8'h00, "R3 open index read");
    @(negedge clk);
    chk(io_rvalid == 1'b0, "R11 no response without read", io_rvalid, 0);

    // page gating
    getreg(8'h30, 8'h00, "R5 watchdog reg without page");
    wr(DT, 8'h01);
    setreg(8'h07, 8'h08);
    rd(DT, 8'h08, "R5 page readback");
    getreg(8'h30, 8'h00, "R2 R5 earlier writes discarded");
    setreg(8'h30, 8'hFF);
    getreg(8'h30, 8'h01, "R6 enable bit only");
    setreg(8'hF5, 8'hFF);
    getreg(8'hF5, 8'h08, "R6 unit bit only");
    setreg(8'hF5, 8'h00);
    setreg(8'hF7, 8'hFF);
    getreg(8'hF7, 8'hC0, "R6 source bits only");
    setreg(8'hF7, 8'h00);
    setreg(8'h40, 8'h5A);
    getreg(8'h40, 8'h00, "R5 unimplemented index");

    // seconds mode
    setreg(8'hF6, 8'h03);
    getreg(8'hF6, 8'h03, "R11 count readback");
    tick(1);
    getreg(8'hF6, 8'h02, "R7 one tick");
    setreg(8'h30, 8'h00);
    tick(2);
    getreg(8'hF6, 8'h02, "R7 disabled holds");
    setreg(8'h30, 8'h01);
    tick(1);
    chk(wdt_timeout == 1'b0, "R9 no timeout at 1", wdt_timeout, 0);
    tick(1);
    chk(wdt_timeout == 1'b1, "R9 timeout at 0", wdt_timeout, 1);
    tick(3);
    chk(wdt_timeout == 1'b1, "R9 timeout held", wdt_timeout, 1);
    getreg(8'hF6, 8'h00, "R9 count stays 0");
    setreg(8'hF6, 8'h02);
    chk(wdt_timeout == 1'b0, "R9 write clears timeout", wdt_timeout, 0);

    // minute mode
    setreg(8'hF5, 8'h08);
    setreg(8'hF6, 8'h02);
    tick(3);
    getreg(8'hF6, 8'h02, "R8 partial minute");
    tick(1);
    getreg(8'hF6, 8'h01, "R8 full minute");
    tick(4);
    chk(wdt_timeout == 1'b1, "R8 R9 minute expiry", wdt_timeout, 1);

    // reload sources
    setreg(8'hF5, 8'h00);
    setreg(8'hF6, 8'h05);
    tick(2);
    kbd();
    getreg(8'hF6, 8'h03, "R10 kbd ignored when bit clear");
    setreg(8'hF7, 8'h40);
    kbd();
    getreg(8'hF6, 8'h05, "R10 kbd reload");
    tick(1);
    mouse();
    getreg(8'hF6, 8'h04, "R10 mouse ignored when bit clear");
    setreg(8'hF7, 8'hC0);
    mouse();
    getreg(8'hF6, 8'h05, "R10 mouse reload");
    tick(5);
    chk(wdt_timeout == 1'b1, "R10 expired before reload", wdt_timeout, 1);
    kbd();
    chk(wdt_timeout == 1'b0, "R10 reload clears timeout", wdt_timeout, 0);
    getreg(8'hF6, 8'h05, "R10 reload value");

    // R12 simultaneous write, reload and tick
    @(negedge clk);
    io_wr = 1'b1; io_addr = DT; io_wdata = 8'h09;
    sec_tick = 1'b1; kbd_evt = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; sec_tick = 1'b0; kbd_evt = 1'b0;
    rd(DT, 8'h09, "R12 host write wins");

    // lock again
    wr(IX, 8'hAA);
    rd(DT, 8'hFF, "R4 locked after close key");
    wr(DT, 8'h00);
    wr(IX, 8'h87); wr(IX, 8'h87);
    rd(IX, 8'hF6, "R4 index kept over lock");
    rd(DT, 8'h09, "R2 R4 locked write ignored");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule